// File: doc/BRIEF.md
# Per-Cycle Overcurrent Fault Integrator

This block watches a switching regulator's overcurrent indications one switching cycle at a time and decides when they add up to a fault. Every cycle strobe is scored against two flags: a low-side average-current compare, whose threshold is set elsewhere and can be changed, and a high-side short-circuit detect, whose threshold is fixed. A saturating up/down counter climbs on cycles that saw either flag and falls on clean cycles. A fault is declared when the count reaches the trip level of three. A few scattered bad cycles therefore never shut the stage down, but a sustained overload always does.

Once a fault is declared, a response mode picks the action. In hiccup restart, switching stops for seven times the programmed soft-start rise time (given in clock ticks) and then resumes. In latch-off, switching stays stopped until the enable input is removed and applied again. In ignore, switching continues. In every mode the fault status bit is set and stays set until software clears it. The alert line follows the status bit unless it is masked.

Top module: `oc_fault_integrator`

## Requirements
- R1: While reset is active and on the first cycle after it, switchEn, faultStatus and alert are all 0. Switching begins on the cycle after enable is first seen high.
- R2: On a clock where cycleStrobe is 1 while running, the count rises by one if lsOverCurrent or hsShortCircuit is 1. Otherwise it falls by one, but never below zero. The flags have no effect on clocks without a strobe.
- R3: A fault is declared on the strobe that would bring the count to three, and the count then restarts from zero. Two bad strobes, one clean strobe and one bad strobe therefore do not trip.
- R4: With respMode 2'b00 or 2'b11 (restart), switchEn drops on the clock after the trip and stays low for max(7*riseTicks, 1) cycles. Switching then resumes with the count at zero.
- R5: With respMode 2'b01 (latch), switchEn stays low after a trip for as long as enable stays high. It returns only once enable has been low for at least one cycle and is then high again.
- R6: With respMode 2'b10 (ignore), a trip sets faultStatus while switchEn stays 1.
- R7: faultStatus sets on the clock after a trip and holds until statusClear is 1 on a clock. A trip on the same clock takes priority over the clear.
- R8: alert equals faultStatus while alertMask is 0 and is 0 while alertMask is 1.
- R9: enable at 0 drops switchEn on the next clock. It also discards the count and cancels any restart delay in progress.
- R10: Strobes that arrive while switching is stopped (off, in the restart delay, or latched) are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; a low-to-high cycle re-arms after latch-off |
| cycleStrobe | input | 1 | One-clock pulse per switching cycle |
| lsOverCurrent | input | 1 | Low-side average current above its programmed fault level in this cycle |
| hsShortCircuit | input | 1 | High-side current above the fixed short-circuit level in this cycle |
| respMode | input | 2 | 00/11 restart, 01 latch off, 10 ignore |
| riseTicks | input | RISE_W | Soft-start rise time in clock ticks |
| statusClear | input | 1 | Clears the sticky fault status |
| alertMask | input | 1 | Suppresses the alert line |
| switchEn | output | 1 | Power-stage switching permitted |
| faultStatus | output | 1 | Sticky overcurrent fault flag |
| alert | output | 1 | Fault alert, active high |

## Verification
On every clock, the embedded assertions check that the count never goes past the trip level, never moves below zero, returns to zero after a trip, and rises by exactly one on a bad strobe. They also check the per-mode reaction on the clock after a trip, that the latched state holds while enabled, that the sticky status holds, and that enable low stops switching. The exact length of the restart delay and the need for a full enable low-high cycle after a latch can only be shown by the bench's timed scenarios. The same holds for the fact that a clean strobe between bad ones postpones the trip, and that strobes are ignored while switching is stopped. The bench follows all of these with a cycle model under directed and random stimulus.

// File: rtl/ocfi_pkg.sv
package ocfi_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RUN     = 2'd1,
    ST_HICCUP  = 2'd2,
    ST_LATCHED = 2'd3
  } ctrlState_t;

  typedef enum logic [1:0] {
    RESP_RESTART     = 2'b00,
    RESP_LATCH       = 2'b01,
    RESP_IGNORE      = 2'b10,
    RESP_RESTART_ALT = 2'b11
  } respMode_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic countEn;    // score this switching cycle
    logic cntClear;   // hold the event count at zero
    logic timerLoad;  // load the restart delay
    logic timerRun;   // restart delay is running
  } dpCtrl_t;

endpackage

// File: rtl/ocfi_datapath.sv
module ocfi_datapath
  import ocfi_pkg::*;
#(
  parameter int TRIP_COUNT = 3,
  parameter int RISE_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              lsOverCurrent,
  input  logic              hsShortCircuit,
  input  logic [RISE_W-1:0] riseTicks,
  output logic              tripNow,
  output logic              timerDone
);

  localparam int CNT_W = $clog2(TRIP_COUNT + 1);
  localparam int TMR_W = RISE_W + 3;
  localparam logic [CNT_W-1:0] LAST_SAFE = CNT_W'(TRIP_COUNT - 1);

  logic [CNT_W-1:0] evCount;
  logic [TMR_W-1:0] holdTimer;
  logic             anyEvent;
  logic [TMR_W-1:0] restartDelay;

  assign anyEvent = lsOverCurrent | hsShortCircuit;

  // seven rise times: 8x minus 1x, no multiplier
  assign restartDelay = (TMR_W'(riseTicks) << 3) - TMR_W'(riseTicks);

  assign tripNow   = ctl.countEn & anyEvent & (evCount == LAST_SAFE);
  assign timerDone = ctl.timerRun & (holdTimer <= TMR_W'(1));

  // saturating up/down event integrator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evCount <= '0;
    end else if (ctl.cntClear || tripNow) begin
      evCount <= '0;
    end else if (ctl.countEn) begin
      if (anyEvent)
        evCount <= evCount + CNT_W'(1);
      else if (evCount != '0)
        evCount <= evCount - CNT_W'(1);
    end
  end

  // restart delay counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdTimer <= '0;
    end else if (ctl.timerLoad) begin
      holdTimer <= restartDelay;
    end else if (ctl.timerRun && holdTimer > TMR_W'(1)) begin
      holdTimer <= holdTimer - TMR_W'(1);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    evCount < CNT_W'(TRIP_COUNT));

  a_r3_clear_on_trip: assert property (@(posedge clk) disable iff (!rstN)
    tripNow |=> evCount == '0);

  a_r2_floor_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !anyEvent && evCount == '0) |=> evCount == '0);

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && anyEvent && !tripNow && !ctl.cntClear)
      |=> evCount == $past(evCount) + CNT_W'(1));

  a_r4_timer_down: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.timerRun && !ctl.timerLoad && holdTimer > TMR_W'(1))
      |=> holdTimer == $past(holdTimer) - TMR_W'(1));

endmodule

// File: rtl/ocfi_ctrl.sv
module ocfi_ctrl
  import ocfi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       cycleStrobe,
  input  logic [1:0] respMode,
  input  logic       statusClear,
  input  logic       alertMask,
  input  logic       tripNow,
  input  logic       timerDone,
  output dpCtrl_t    ctl,
  output logic       switchEn,
  output logic       faultStatus,
  output logic       alert
);

  ctrlState_t state, stateNext;
  logic isLatch, isIgnore, isRestart;

  assign isLatch   = (respMode == RESP_LATCH);
  assign isIgnore  = (respMode == RESP_IGNORE);
  assign isRestart = !isLatch && !isIgnore;

  always_comb begin
    ctl.countEn   = (state == ST_RUN) & enable & cycleStrobe;
    ctl.cntClear  = (state != ST_RUN);
    ctl.timerLoad = tripNow & isRestart;
    ctl.timerRun  = (state == ST_HICCUP) & enable;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF:     if (enable) stateNext = ST_RUN;
      ST_RUN: begin
        if (!enable)       stateNext = ST_OFF;
        else if (tripNow) begin
          if (isLatch)       stateNext = ST_LATCHED;
          else if (isIgnore) stateNext = ST_RUN;
          else               stateNext = ST_HICCUP;
        end
      end
      ST_HICCUP: begin
        if (!enable)        stateNext = ST_OFF;
        else if (timerDone) stateNext = ST_RUN;
      end
      ST_LATCHED: if (!enable) stateNext = ST_OFF;
      default:    stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)            faultStatus <= 1'b0;
    else if (tripNow)     faultStatus <= 1'b1;
    else if (statusClear) faultStatus <= 1'b0;
  end

  assign switchEn = (state == ST_RUN);
  assign alert    = faultStatus & ~alertMask;

  a_r4_restart_stops: assert property (@(posedge clk) disable iff (!rstN)
    (tripNow && isRestart) |=> !switchEn);

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCHED && enable) |=> state == ST_LATCHED);

  a_r6_ignore_runs: assert property (@(posedge clk) disable iff (!rstN)
    (tripNow && isIgnore && enable) |=> (switchEn && faultStatus));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus && !statusClear) |=> faultStatus);

  a_r9_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !switchEn);

endmodule

// File: rtl/oc_fault_integrator.sv
module oc_fault_integrator
  import ocfi_pkg::*;
#(
  parameter int TRIP_COUNT = 3,
  parameter int RISE_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cycleStrobe,
  input  logic              lsOverCurrent,
  input  logic              hsShortCircuit,
  input  logic [1:0]        respMode,
  input  logic [RISE_W-1:0] riseTicks,
  input  logic              statusClear,
  input  logic              alertMask,
  output logic              switchEn,
  output logic              faultStatus,
  output logic              alert
);

  dpCtrl_t ctl;
  logic    tripNow;
  logic    timerDone;

  ocfi_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .cycleStrobe (cycleStrobe),
    .respMode    (respMode),
    .statusClear (statusClear),
    .alertMask   (alertMask),
    .tripNow     (tripNow),
    .timerDone   (timerDone),
    .ctl         (ctl),
    .switchEn    (switchEn),
    .faultStatus (faultStatus),
    .alert       (alert)
  );

  ocfi_datapath #(
    .TRIP_COUNT (TRIP_COUNT),
    .RISE_W     (RISE_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .lsOverCurrent  (lsOverCurrent),
    .hsShortCircuit (hsShortCircuit),
    .riseTicks      (riseTicks),
    .tripNow        (tripNow),
    .timerDone      (timerDone)
  );

endmodule

// File: tb/sim_oc_fault_integrator.sv
module sim_oc_fault_integrator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0, cycleStrobe = 1'b0;
  logic        lsOverCurrent = 1'b0, hsShortCircuit = 1'b0;
  logic [1:0]  respMode = 2'b00;
  logic [15:0] riseTicks = 16'd3;
  logic        statusClear = 1'b0, alertMask = 1'b0;
  logic        switchEn, faultStatus, alert;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // model: 0 off, 1 run, 2 restart delay, 3 latched
  int mState = 0, mCnt = 0, mTimer = 0;
  bit mStatus = 1'b0;

  always #10 clk = ~clk;

  oc_fault_integrator u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .cycleStrobe(cycleStrobe),
    .lsOverCurrent(lsOverCurrent), .hsShortCircuit(hsShortCircuit),
    .respMode(respMode), .riseTicks(riseTicks), .statusClear(statusClear),
    .alertMask(alertMask), .switchEn(switchEn), .faultStatus(faultStatus),
    .alert(alert)
  );

  function automatic int restartLen(int rise);
    return (7 * rise < 1) ? 1 : 7 * rise;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit trip = 1'b0;
    case (mState)
      0: begin mCnt = 0; if (enable) mState = 1; end
      1: begin
        if (!enable) begin mState = 0; mCnt = 0; end
        else if (cycleStrobe) begin
          if ((lsOverCurrent || hsShortCircuit) && mCnt == 2) begin
            trip = 1'b1; mCnt = 0;
            if (respMode == 2'b01) mState = 3;
            else if (respMode == 2'b10) mState = 1;
            else begin mState = 2; mTimer = 7 * int'(riseTicks); end
          end else if (lsOverCurrent || hsShortCircuit) mCnt++;
          else if (mCnt > 0) mCnt--;
        end
      end
      2: begin
        mCnt = 0;
        if (!enable) mState = 0;
        else if (mTimer <= 1) mState = 1;
        else mTimer--;
      end
      default: begin mCnt = 0; if (!enable) mState = 0; end
    endcase
    if (trip) mStatus = 1'b1;
    else if (statusClear) mStatus = 1'b0;
  endtask

  task automatic compareAll();
    chk(curReq, "switchEn", int'(switchEn), int'(mState == 1));
    chk(curReq, "faultStatus", int'(faultStatus), int'(mStatus));
    chk("R8", "alert", int'(alert), int'(mStatus && !alertMask));
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic pulse(bit ls, bit hs);
    cycleStrobe = 1'b1; lsOverCurrent = ls; hsShortCircuit = hs;
    tick();
    cycleStrobe = 1'b0; lsOverCurrent = 1'b0; hsShortCircuit = 1'b0;
    tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    int offCycles;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "switchEn in reset", int'(switchEn), 0);
    chk("R1", "faultStatus in reset", int'(faultStatus), 0);
    chk("R1", "alert in reset", int'(alert), 0);
    rstN = 1'b1;
    tick();
    chk("R1", "switchEn after reset", int'(switchEn), 0);
    enable = 1'b1;
    tick();
    chk("R1", "switchEn after enable", int'(switchEn), 1);

    // R2: flags without a strobe do nothing
    curReq = "R2";
    lsOverCurrent = 1'b1; hsShortCircuit = 1'b1;
    repeat (6) tick();
    lsOverCurrent = 1'b0; hsShortCircuit = 1'b0;
    // R2: floor at zero -- many clean strobes then two bad ones must not trip
    repeat (4) pulse(0, 0);
    pulse(1, 0); pulse(0, 1);
    chk("R2", "no trip after floor", int'(faultStatus), 0);
    pulse(0, 0);
    // R3: count is now 1; one more bad brings 2, still no trip
    curReq = "R3";
    pulse(1, 1);
    chk("R3", "no trip at two", int'(faultStatus), 0);
    // R4: trip in restart mode, rise 3 -> 21 off cycles
    respMode = 2'b00; riseTicks = 16'd3;
    cycleStrobe = 1'b1; hsShortCircuit = 1'b1;
    curReq = "R4";
    tick();
    cycleStrobe = 1'b0; hsShortCircuit = 1'b0;
    chk("R3", "trip at three", int'(faultStatus), 1);
    offCycles = 0;
    while (!switchEn && offCycles < 100) begin offCycles++; tick(); end
    chk("R4", "restart off cycles", offCycles, restartLen(3));
    // R10: strobes during delay not counted; restart alt code 11 with rise 0
    respMode = 2'b11; riseTicks = 16'd0;
    pulse(1, 0); pulse(1, 0);
    curReq = "R10";
    cycleStrobe = 1'b1; lsOverCurrent = 1'b1; tick(); // trip
    tick(); // in delay, strobe ignored
    cycleStrobe = 1'b0; lsOverCurrent = 1'b0;
    chk("R4", "rise zero gives one off cycle", int'(switchEn), 1);
    pulse(1, 0); pulse(1, 0);
    chk("R10", "count restarted at zero", int'(switchEn), 1);
    pulse(0, 0); pulse(0, 0);

    // R7: clear status
    curReq = "R7";
    statusClear = 1'b1; tick(); statusClear = 1'b0; tick();
    chk("R7", "status cleared", int'(faultStatus), 0);

    // R5: latch
    curReq = "R5";
    respMode = 2'b01;
    pulse(1, 0); pulse(1, 0); pulse(0, 1);
    repeat (40) tick();
    chk("R5", "still latched", int'(switchEn), 0);
    pulse(1, 1);
    enable = 1'b0; tick();
    enable = 1'b1; tick();
    chk("R5", "released by enable cycle", int'(switchEn), 1);

    // R6: ignore, with set winning over clear (R7)
    curReq = "R6";
    respMode = 2'b10;
    statusClear = 1'b1; tick(); statusClear = 1'b0;
    pulse(1, 0); pulse(1, 0);
    statusClear = 1'b1; cycleStrobe = 1'b1; lsOverCurrent = 1'b1; tick();
    statusClear = 1'b0; cycleStrobe = 1'b0; lsOverCurrent = 1'b0;
    chk("R6", "switching kept", int'(switchEn), 1);
    chk("R7", "set wins over clear", int'(faultStatus), 1);

    // R8: mask
    alertMask = 1'b1; tick();
    chk("R8", "masked alert", int'(alert), 0);
    alertMask = 1'b0; tick();
    chk("R8", "unmasked alert", int'(alert), 1);

    // R9: enable drop during restart delay
    curReq = "R9";
    respMode = 2'b00; riseTicks = 16'd20;
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    repeat (5) tick();
    enable = 1'b0; tick();
    chk("R9", "off while disabled", int'(switchEn), 0);
    enable = 1'b1; tick();
    chk("R9", "delay cancelled", int'(switchEn), 1);
    pulse(1, 0); pulse(1, 0);
    enable = 1'b0; tick(); enable = 1'b1; tick();
    pulse(1, 0); pulse(1, 0);
    chk("R9", "count discarded", int'(switchEn), 1);

    // random phase
    curReq = "R2 random";
    for (int i = 0; i < 6000; i++) begin
      cycleStrobe    = ($urandom_range(0, 3) == 0);
      lsOverCurrent  = ($urandom_range(0, 2) == 0);
      hsShortCircuit = ($urandom_range(0, 5) == 0);
      statusClear    = ($urandom_range(0, 40) == 0);
      alertMask      = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 150) == 0) respMode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 150) == 0) riseTicks = 16'($urandom_range(0, 6));
      if ($urandom_range(0, 200) == 0) enable = ~enable;
      else if (!enable && $urandom_range(0, 4) == 0) enable = 1'b1;
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule